// File: doc/BRIEF.md
# Phase-Aligned Three-Bank Clock Divider

The block takes one input clock and drives three output banks. Each bank shows the input clock itself, half of it or a quarter of it, and the choice is made per bank. All three banks take their divided waveform from one shared two-bit counter, so a rising edge on any bank is always launched by the same input edge as a rising edge on every other bank.

Start-up is controlled by an active-high asynchronous reset and a level enable. The enable passes through a synchronizer and is then held for a fixed number of input cycles. After that the outputs are released with the counter at zero. Every bank therefore starts with a complete high phase on the same input edge, with no shortened pulse. The pass-through bank is gated by a copy of the release flag captured on the falling edge, so it can only switch on while the clock is low. Ratio selects are captured only while the block is stopped.

Top module: `mbclk_div`

## Requirements
- R1: Each bank b has a 2-bit select at `ratio_sel[2b+1:2b]`. Code 00 selects divide-by-1, 01 selects divide-by-2, and both 10 and 11 select divide-by-4. Each bank is set independently of the others.
- R2: A running divide-by-1 bank is high during every high half of the input clock and low during every low half. Its first pulse has full width.
- R3: A running divide-by-2 bank is high for one input cycle and then low for one. A running divide-by-4 bank is high for two input cycles and then low for two. Every transition is on a rising input edge.
- R4: Count as edge 1 the first rising input edge that samples `enable` high. All outputs stay low until edge 7, and the first output rise comes at edge 7. This is two synchronizer cycles plus four hold cycles.
- R5: On release, every bank starts with its high phase on the same rising input edge, and that high phase has full width.
- R6: While `mreset` is high, all outputs are low. Raising `mreset` forces the outputs low at once, without waiting for a clock edge. After `mreset` falls with `enable` already high, the R4 sequence runs again.
- R7: Count as edge 1 the first rising edge that samples `enable` low. From edge 4 on, every output is low and stays low while `enable` remains low.
- R8: If `enable` drops for two or more cycles during the hold period, the hold count restarts. The R4 timing is then measured from the next rise of `enable`.
- R9: A change to `ratio_sel` while the outputs run has no effect on them. The new codes take effect from the next release after a disable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided and fanned out |
| mreset | input | 1 | Asynchronous master reset, active high |
| enable | input | 1 | Output enable, asynchronous to nothing, synchronized inside |
| ratio_sel | input | 2*NUM_BANKS | Per-bank ratio codes, two bits per bank |
| bank_out | output | NUM_BANKS | Output banks |

## Verification
Every result is due a fixed number of cycles after its stimulus:
- the first output rise comes on the seventh rising edge after `enable` is raised;
- outputs are silent from the fourth rising edge after `enable` is dropped;
- raising `mreset` clears the outputs within the same half cycle, with no edge.

The bench drives inputs half a nanosecond after a falling edge. It reads the outputs 1.25 ns into each high half and each low half of the clock, so it reads the pass-through bank and the divided banks by the same rule. It keeps a cycle index that is negative during the hold window and zero on the first released edge. From that index it computes the expected level for every bank and every half cycle, so an early or late release by one edge shows up as a mismatch.

// File: rtl/mbclk_pkg.sv
`timescale 1ns/1ps
package mbclk_pkg;
  // ratio codes; 11 behaves as divide-by-4
  typedef enum logic [1:0] {
    RATIO_1  = 2'b00,
    RATIO_2  = 2'b01,
    RATIO_4  = 2'b10,
    RATIO_4B = 2'b11
  } ratio_e;

  localparam int SEL_W = 2;
  localparam int CNT_W = 2;
endpackage

// File: rtl/mbclk_en_sync.sv
`timescale 1ns/1ps
module mbclk_en_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or posedge rst) begin
        if (rst) sh_q <= '0;
        else     sh_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or posedge rst) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/mbclk_release_seq.sv
`timescale 1ns/1ps
module mbclk_release_seq #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  output logic run_o,
  output logic run_neg_o
);
  localparam int HCNT_W = $clog2(HOLD + 1);
  localparam logic [HCNT_W-1:0] HOLD_LAST = HCNT_W'(HOLD - 1);

  logic [HCNT_W-1:0] hcnt_q;
  logic              run_q;
  logic              run_n_q;

  // hold counter restarts whenever the synchronized enable is low
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      hcnt_q <= '0;
      run_q  <= 1'b0;
    end else if (!en_i) begin
      hcnt_q <= '0;
      run_q  <= 1'b0;
    end else if (!run_q) begin
      if (hcnt_q == HOLD_LAST) run_q  <= 1'b1;
      else                     hcnt_q <= hcnt_q + 1'b1;
    end
  end

  // falling-edge copy: the pass-through gate only moves while the clock is low
  always_ff @(negedge clk or posedge rst) begin
    if (rst) run_n_q <= 1'b0;
    else     run_n_q <= run_q;
  end

  assign run_o     = run_q;
  assign run_neg_o = run_n_q;

  // R4
  hold_len_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(run_q) |-> ($past(hcnt_q) == HOLD_LAST) && $past(en_i));
endmodule

// File: rtl/mbclk_div_counter.sv
`timescale 1ns/1ps
module mbclk_div_counter
  import mbclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run_neg_i,
  output logic             live_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             live_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      live_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      live_q <= run_neg_i;
      cnt_q  <= live_q ? cnt_q + 1'b1 : '0;
    end
  end

  assign live_o = live_q;
  assign cnt_o  = cnt_q;

  // R5
  start_phase_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(live_q) |-> (cnt_q == '0));
endmodule

// File: rtl/mbclk_bank_gate.sv
`timescale 1ns/1ps
module mbclk_bank_gate
  import mbclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             run_neg_i,
  input  logic             live_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             out_o
);
  ratio_e ratio_q;

  // select is only taken while the block is stopped
  always_ff @(posedge clk or posedge rst) begin
    if (rst)         ratio_q <= RATIO_1;
    else if (!run_i) ratio_q <= ratio_e'(sel_i);
  end

  always_comb begin
    case (ratio_q)
      RATIO_1: out_o = clk & run_neg_i;
      RATIO_2: out_o = live_i & ~cnt_i[0];
      default: out_o = live_i & ~cnt_i[1];
    endcase
  end

  // R9
  sel_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    live_i |-> $stable(ratio_q));
endmodule

// File: rtl/mbclk_div.sv
`timescale 1ns/1ps
module mbclk_div
  import mbclk_pkg::*;
#(
  parameter int NUM_BANKS   = 3,
  parameter int HOLD_CYCLES = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk_in,
  input  logic                       mreset,
  input  logic                       enable,
  input  logic [SEL_W*NUM_BANKS-1:0] ratio_sel,
  output logic [NUM_BANKS-1:0]       bank_out
);
  logic             sync_en;
  logic             run;
  logic             run_neg;
  logic             live;
  logic [CNT_W-1:0] cnt;

  mbclk_en_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk_in),
    .rst (mreset),
    .d_i (enable),
    .q_o (sync_en)
  );

  mbclk_release_seq #(.HOLD(HOLD_CYCLES)) u_rel (
    .clk       (clk_in),
    .rst       (mreset),
    .en_i      (sync_en),
    .run_o     (run),
    .run_neg_o (run_neg)
  );

  mbclk_div_counter u_cnt (
    .clk       (clk_in),
    .rst       (mreset),
    .run_neg_i (run_neg),
    .live_o    (live),
    .cnt_o     (cnt)
  );

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      mbclk_bank_gate u_gate (
        .clk       (clk_in),
        .rst       (mreset),
        .run_i     (run),
        .run_neg_i (run_neg),
        .live_i    (live),
        .cnt_i     (cnt),
        .sel_i     (ratio_sel[SEL_W*b +: SEL_W]),
        .out_o     (bank_out[b])
      );
    end
  endgenerate

  // R6
  rst_quiet_chk: assert property (@(posedge clk_in)
    mreset |-> (bank_out == '0));

  // R7
  stop_quiet_chk: assert property (@(posedge clk_in) disable iff (mreset)
    $past(!sync_en, 2) |-> !live);
endmodule

// File: tb/test_mbclk_div.sv
`timescale 1ns/1ps
module test_mbclk_div;
  localparam int NB = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en  = 1'b0;
  logic [2*NB-1:0] sel = '0;
  logic [NB-1:0]   bout;
  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  mbclk_div #(.NUM_BANKS(NB), .HOLD_CYCLES(4), .SYNC_STAGES(2)) i_mbclk_div (
    .clk_in    (clk),
    .mreset    (rst),
    .enable    (en),
    .ratio_sel (sel),
    .bank_out  (bout)
  );

  task automatic chk_eq(string req, logic [NB-1:0] got, logic [NB-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b t=%0t", req, got, exp, $time);
    end
  endtask

  // expected level of one bank; n<0 is the hold window, hi=1 for the clock-high half
  function automatic logic exp_bit(logic [1:0] code, int n, bit hi);
    if (n < 0) return 1'b0;
    case (code)
      2'b00:   return hi;
      2'b01:   return (n % 2) == 0;
      default: return (n % 4) < 2;
    endcase
  endfunction

  function automatic logic [NB-1:0] exp_vec(logic [2*NB-1:0] s, int n, bit hi);
    logic [NB-1:0] v;
    for (int b = 0; b < NB; b++) v[b] = exp_bit(s[2*b +: 2], n, hi);
    return v;
  endfunction

  task automatic sample(output logic [NB-1:0] h, output logic [NB-1:0] l);
    @(posedge clk); #1.25 h = bout;
    @(negedge clk); #1.25 l = bout;
  endtask

  task automatic check_run(logic [2*NB-1:0] s, int n0, int cnt, string tag);
    logic [NB-1:0] h, l;
    for (int i = 0; i < cnt; i++) begin
      int n = n0 + i;
      sample(h, l);
      if (n < 0) begin
        chk_eq("R4 hold hi", h, '0);
        chk_eq("R4 hold lo", l, '0);
      end else begin
        chk_eq({tag, " R1/R2/R3 hi"}, h, exp_vec(s, n, 1'b1));
        chk_eq({tag, " R1/R2/R3 lo"}, l, exp_vec(s, n, 1'b0));
        if (n == 0) chk_eq("R5 common start", h, '1);
      end
    end
  endtask

  task automatic enable_and_check(logic [2*NB-1:0] s, int ncyc, string tag);
    @(negedge clk); #0.5 en = 1'b1;
    check_run(s, -6, 6 + ncyc, tag);
  endtask

  task automatic disable_and_check();
    logic [NB-1:0] h, l;
    @(negedge clk); #0.5 en = 1'b0;
    for (int k = 1; k <= 8; k++) begin
      sample(h, l);
      if (k >= 4) begin
        chk_eq("R7 stopped hi", h, '0);
        chk_eq("R7 stopped lo", l, '0);
      end
    end
  endtask

  task automatic t_reset_state();
    logic [NB-1:0] h, l;
    for (int k = 0; k < 3; k++) begin
      sample(h, l);
      chk_eq("R6 reset state hi", h, '0);
      chk_eq("R6 reset state lo", l, '0);
    end
    @(negedge clk); #0.5 rst = 1'b0;
  endtask

  task automatic t_all_combos();
    for (int s = 0; s < 64; s++) begin
      @(negedge clk); #0.5 sel = 6'(s);
      enable_and_check(6'(s), 8, "combo");
      disable_and_check();
    end
  endtask

  task automatic t_sel_ignored();
    logic [2*NB-1:0] a = 6'b10_01_00;
    logic [2*NB-1:0] b = 6'b00_10_01;
    @(negedge clk); #0.5 sel = a;
    enable_and_check(a, 4, "R9 before");
    sel = b;
    check_run(a, 4, 12, "R9 sel ignored");
    disable_and_check();
    enable_and_check(b, 8, "R9 new sel");
    disable_and_check();
  endtask

  task automatic t_async_reset();
    logic [NB-1:0] h, l;
    logic [2*NB-1:0] a = 6'b01_00_10;
    @(negedge clk); #0.5 sel = a;
    enable_and_check(a, 4, "R6 pre");
    @(posedge clk); #0.5 rst = 1'b1;
    #0.5 chk_eq("R6 async clear", bout, '0);
    for (int k = 0; k < 2; k++) begin
      sample(h, l);
      chk_eq("R6 held hi", h, '0);
      chk_eq("R6 held lo", l, '0);
    end
    @(negedge clk); #0.5 rst = 1'b0;
    check_run(a, -6, 14, "R6 restart");
    disable_and_check();
  endtask

  task automatic t_restart();
    logic [NB-1:0] h, l;
    logic [2*NB-1:0] a = 6'b11_01_00;
    @(negedge clk); #0.5 sel = a;
    @(negedge clk); #0.5 en = 1'b1;
    for (int k = 0; k < 2; k++) begin
      sample(h, l);
      chk_eq("R8 early hi", h, '0);
    end
    en = 1'b0;
    for (int k = 0; k < 2; k++) begin
      sample(h, l);
      chk_eq("R8 gap hi", h, '0);
    end
    en = 1'b1;
    check_run(a, -6, 12, "R8 restart");
    disable_and_check();
  endtask

  initial begin : watchdog
    #(200000 * 5);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_all_combos();
    t_sel_ignored();
    t_async_reset();
    t_restart();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule